// File: doc/BRIEF.md
# Memory-Mapped GPIO Pin Bank

This block is a bank of general-purpose I/O pins controlled over a plain 32-bit register bus made of an address, a write enable, write data and registered read data. Each pin has a direction bit and an output latch. The latch is changed only by writing ones to a set word or to a clear word. The bank also holds a two-bit alternate-function selector per pin and a synchronised copy of each pin's input level that can be read back.

The pin count is a parameter and must be 64 or 96. Registers are grouped by function, and each function takes as many consecutive 32-bit words as the pin count needs, which is the pin count divided by 32. The pad side is three vectors: output value, output enable and input value. The alternate-function selectors are also brought out, so that neighbouring logic can route pins to other functions. Edge detection is handled by a separate block, and the words reserved for it read as zero here.

Top module: `gpio_bank`

## Requirements
- R1: While reset is high, and after it is released, every pin is an input, every output latch is 0 and every alternate-function field is 0. So `pad_oe`, `pad_out` and `alt_sel` are all zero.
- R2: With W = pin count / 32, the byte address of function f for pin p is f*W*4 + (p/32)*4, and the pin occupies bit p mod 32 of that word. The function indices are: level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge-status 6, alternate-function 7.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. A pin's `pad_oe` is high exactly when its direction bit is 1 and its alternate-function field is 0. The direction words read back the value written.
- R4: Writing a word to a set address raises the output latch of every pin whose bit is 1, and leaves the other pins as they were. The result appears on `pad_out` on the next clock edge.
- R5: Writing a word to a clear address lowers the output latch of every pin whose bit is 1, and leaves the other pins as they were.
- R6: The set and clear words always read as zero.
- R7: `pad_in` passes through two flip-flop stages before the level words. A change is visible to a read issued two cycles after the change and not to one issued a cycle earlier. Writes to the level words are ignored.
- R8: The alternate-function field of pin p is 2 bits wide, at bits (p mod 16)*2 of the word at byte address 7*W*4 + (p/16)*4. It reads back as written and drives `alt_sel[2p+1:2p]`. A value of 0 selects plain GPIO.
- R9: A pin whose alternate-function field is non-zero has `pad_oe` low, whatever its direction bit.
- R10: Read data appears on `bus_rdata` on the clock edge after the address is presented. The rising-enable, falling-enable and edge-status words, and every address past the last alternate-function word, read as zero and ignore writes.
- R11: `pad_out` shows the output latch even while the pin is an input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pad_in | input | NUM_PINS | Pin input levels, asynchronous |
| pad_out | output | NUM_PINS | Output latch per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| alt_sel | output | 2*NUM_PINS | Alternate-function selector, two bits per pin |

## Verification
The set and clear words are written with several masks:
- masks that touch only one word of the bank, which shows that the pin-to-word mapping is right;
- masks that cover both ends of a word (bits 0 and 31);
- an all-zero mask, which shows that zero bits leave the latch alone.

The level words are read with a mixed input pattern in both words. A read is issued one cycle and then two cycles after a change on `pad_in`, which separates a correct two-stage synchroniser from a shorter or longer one.

The alternate-function fields are written for one pin in the low half of a word and one pin in the upper half of a later word. This shows that the packing is two bits per pin and sixteen pins per word. It also shows that a non-zero field overrides the direction bit on both an existing output and a newly set one. Writes to reserved and out-of-range addresses are followed by checks that the pads and the selectors have not changed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Function index: multiplied by words-per-function to form the word base.
  typedef enum logic [2:0] {
    FN_LEVEL = 3'd0,
    FN_DIR   = 3'd1,
    FN_SET   = 3'd2,
    FN_CLR   = 3'd3,
    FN_RISE  = 3'd4,
    FN_FALL  = 3'd5,
    FN_EDGE  = 3'd6,
    FN_ALT   = 3'd7
  } gpio_fn_e;

  localparam int unsigned BUS_W         = 32;
  localparam int unsigned PINS_PER_WORD = 32;
  localparam int unsigned ALT_PER_WORD  = 16;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

  // R7: the output equals the input sampled two edges earlier.
  a_r7_two_stage: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WORDS  = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SUB_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_fn_e          fn,
  output logic [SUB_W-1:0]  sub,
  output logic              hit
);

  localparam logic [31:0] ALT_BASE = 32'(7 * WORDS);
  localparam logic [31:0] ALT_END  = 32'(9 * WORDS);

  logic [31:0] widx;
  assign widx = 32'(addr[ADDR_W-1:2]);

  always_comb begin
    fn  = FN_LEVEL;
    sub = '0;
    hit = 1'b0;
    if (widx < ALT_BASE) begin
      fn  = gpio_fn_e'(3'(widx / WORDS));
      sub = SUB_W'(widx % WORDS);
      hit = 1'b1;
    end else if (widx < ALT_END) begin
      fn  = FN_ALT;
      sub = SUB_W'(widx - ALT_BASE);
      hit = 1'b1;
    end
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_dir,
  input  logic                 wr_set,
  input  logic                 wr_clr,
  input  logic                 wr_alt_lo,
  input  logic                 wr_alt_hi,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     dir_o,
  output logic [BUS_W-1:0]     out_o,
  output logic [2*BUS_W-1:0]   alt_o,
  output logic [BUS_W-1:0]     oe_o
);

  logic [BUS_W-1:0]   dir_q;
  logic [BUS_W-1:0]   out_q;
  logic [2*BUS_W-1:0] alt_q;
  logic [BUS_W-1:0]   set_mask;
  logic [BUS_W-1:0]   clr_mask;

  assign set_mask = wr_set ? wdata : '0;
  assign clr_mask = wr_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      alt_q <= '0;
    end else begin
      if (wr_dir)    dir_q <= wdata;
      out_q <= (out_q | set_mask) & ~clr_mask;
      if (wr_alt_lo) alt_q[BUS_W-1:0]       <= wdata;
      if (wr_alt_hi) alt_q[2*BUS_W-1:BUS_W] <= wdata;
    end
  end

  for (genvar i = 0; i < int'(BUS_W); i++) begin : g_oe
    assign oe_o[i] = dir_q[i] & ~(|alt_q[2*i +: 2]);
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign alt_o = alt_q;

  // R1: state is cleared on the edge after reset.
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_q == '0 && dir_q == '0 && alt_q == '0));

  // R4: every written one is high afterwards.
  a_r4_set_ones: assert property (@(posedge clk) disable iff (rst)
    (wr_set && !wr_clr) |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R5: every written one is low afterwards.
  a_r5_clr_ones: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((out_q & $past(wdata)) == '0));

  // R4, R5: without a set or clear write the latch holds.
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_set && !wr_clr) |=> $stable(out_q));

  // R3: the direction word changes only on its own write.
  a_r3_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [2*NUM_PINS-1:0] alt_sel
);

  localparam int unsigned WORDS = NUM_PINS / PINS_PER_WORD;
  localparam int unsigned SUB_W = $clog2(2 * WORDS);

  gpio_fn_e         dec_fn;
  logic [SUB_W-1:0] dec_sub;
  logic             dec_hit;
  logic             wr_ok;

  logic [NUM_PINS-1:0] level_sync;
  logic [BUS_W-1:0]    lvl_w [WORDS];
  logic [BUS_W-1:0]    dir_w [WORDS];
  logic [BUS_W-1:0]    alt_w [2*WORDS];
  logic [BUS_W-1:0]    rd_next;

  gpio_addr_dec #(
    .WORDS  (WORDS),
    .ADDR_W (ADDR_W),
    .SUB_W  (SUB_W)
  ) i_dec (
    .addr (bus_addr),
    .fn   (dec_fn),
    .sub  (dec_sub),
    .hit  (dec_hit)
  );

  gpio_sync #(
    .WIDTH (NUM_PINS)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (level_sync)
  );

  assign wr_ok = bus_we & dec_hit;

  for (genvar k = 0; k < int'(WORDS); k++) begin : g_word
    logic [2*BUS_W-1:0] slice_alt;

    gpio_pin_slice i_slice (
      .clk       (clk),
      .rst       (rst),
      .wr_dir    (wr_ok && dec_fn == FN_DIR && dec_sub == SUB_W'(k)),
      .wr_set    (wr_ok && dec_fn == FN_SET && dec_sub == SUB_W'(k)),
      .wr_clr    (wr_ok && dec_fn == FN_CLR && dec_sub == SUB_W'(k)),
      .wr_alt_lo (wr_ok && dec_fn == FN_ALT && dec_sub == SUB_W'(2*k)),
      .wr_alt_hi (wr_ok && dec_fn == FN_ALT && dec_sub == SUB_W'(2*k+1)),
      .wdata     (bus_wdata),
      .dir_o     (dir_w[k]),
      .out_o     (pad_out[k*BUS_W +: BUS_W]),
      .alt_o     (slice_alt),
      .oe_o      (pad_oe[k*BUS_W +: BUS_W])
    );

    assign alt_w[2*k]   = slice_alt[BUS_W-1:0];
    assign alt_w[2*k+1] = slice_alt[2*BUS_W-1:BUS_W];
    assign lvl_w[k]     = level_sync[k*BUS_W +: BUS_W];
    assign alt_sel[k*2*BUS_W +: 2*BUS_W] = slice_alt;
  end

  always_comb begin
    rd_next = '0;
    if (dec_hit) begin
      case (dec_fn)
        FN_LEVEL: if (32'(dec_sub) < WORDS)     rd_next = lvl_w[dec_sub];
        FN_DIR:   if (32'(dec_sub) < WORDS)     rd_next = dir_w[dec_sub];
        FN_ALT:   if (32'(dec_sub) < 2 * WORDS) rd_next = alt_w[dec_sub];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R6: the write-one words read as zero.
  a_r6_setclr_read_zero: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && (dec_fn == FN_SET || dec_fn == FN_CLR)) |=> (bus_rdata == '0));

  // R10: the edge-related words and unmapped addresses read as zero.
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (!dec_hit || dec_fn == FN_RISE || dec_fn == FN_FALL || dec_fn == FN_EDGE)
      |=> (bus_rdata == '0));

  // R10: a write that maps to nothing leaves the pads and selectors unchanged.
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !dec_hit) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(alt_sel)));

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;

  localparam int unsigned NP = 64;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [2*NP-1:0] alt_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_bank (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt_sel   (alt_sel)
  );

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Driver tasks: change inputs at the falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    sb_q.push_back('{exp: exp, tag: tag});
  endtask

  // Monitor: each read is compared just after the edge that registers it.
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        #1;
        check({96'd0, bus_rdata}, {96'd0, it.exp}, it.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Address map for 64 pins: W = 2 words per function.
  // level 0x00/0x04, dir 0x08/0x0C, set 0x10/0x14, clr 0x18/0x1C,
  // rise 0x20, edge 0x30, alt 0x38..0x44, first unmapped 0x48.
  initial begin
    repeat (3) @(negedge clk);
    check({64'd0, pad_oe}, 128'd0, "R1 pad_oe in reset");
    rst = 1'b0;
    @(negedge clk);
    check({64'd0, pad_oe}, 128'd0, "R1 pad_oe after reset");
    check({64'd0, pad_out}, 128'd0, "R1 pad_out after reset");
    check(alt_sel, 128'd0, "R1 alt_sel after reset");
    rd(8'h08, 32'h0, "R1 dir word0 reset");
    rd(8'h3C, 32'h0, "R1 alt word1 reset");

    // R3 direction
    wr(8'h08, 32'h0000_00FF);
    check({64'd0, pad_oe}, 128'hFF, "R3 outputs enabled");
    rd(8'h08, 32'h0000_00FF, "R3 dir readback");

    // R4 set, R2 word mapping
    wr(8'h10, 32'h0000_000F);
    check({64'd0, pad_out}, 128'hF, "R4 set low nibble");
    wr(8'h14, 32'h8000_0001);
    check({64'd0, pad_out}, 128'h8000_0001_0000_000F, "R2 set word1 pins 32 and 63");
    wr(8'h10, 32'h0);
    check({64'd0, pad_out}, 128'h8000_0001_0000_000F, "R4 zero mask no effect");

    // R5 clear
    wr(8'h18, 32'h0000_0003);
    check({64'd0, pad_out}, 128'h8000_0001_0000_000C, "R5 clear bits 0 and 1");
    wr(8'h1C, 32'h8000_0000);
    check({64'd0, pad_out}, 128'h0000_0001_0000_000C, "R5 clear pin 63");

    // R6
    rd(8'h10, 32'h0, "R6 set word reads zero");
    rd(8'h1C, 32'h0, "R6 clear word reads zero");

    // R11 latch visible on an input pin
    check({127'd0, pad_out[32]}, 128'd1, "R11 pad_out on input pin 32");
    check({127'd0, pad_oe[32]}, 128'd0, "R11 pin 32 still input");

    // R7 level readback
    @(negedge clk);
    pad_in = 64'hA5A5_0000_1234_5678;
    repeat (3) @(negedge clk);
    rd(8'h00, 32'h1234_5678, "R7 level word0");
    rd(8'h04, 32'hA5A5_0000, "R7 level word1");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h1234_5678, "R7 level write ignored");

    // R7 synchroniser latency
    @(negedge clk);
    pad_in = 64'h0000_0000_CAFE_0001;
    rd(8'h00, 32'h1234_5678, "R7 one cycle after change still old");
    rd(8'h00, 32'hCAFE_0001, "R7 two cycles after change new");

    // R8, R9 alternate function
    wr(8'h38, 32'h0000_0020);
    check(alt_sel, 128'h20, "R8 pin 2 field");
    check({64'd0, pad_oe}, 128'hFB, "R9 alt forces pin 2 oe off");
    wr(8'h40, 32'h0003_0000);
    check(alt_sel, 128'h0000_0000_0003_0000_0000_0000_0000_0020, "R8 pin 40 field");
    rd(8'h40, 32'h0003_0000, "R8 alt word2 readback");
    rd(8'h44, 32'h0, "R8 alt word3 untouched");
    wr(8'h0C, 32'h0000_0100);
    check({64'd0, pad_oe}, 128'hFB, "R9 pin 40 output blocked by alt");
    wr(8'h40, 32'h0);
    check({64'd0, pad_oe}, 128'h0000_0100_0000_00FB, "R3 pin 40 oe after alt cleared");

    // R10 reserved and unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R10 rising word reads zero");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h0, "R10 edge word reads zero");
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, 32'h0, "R10 unmapped reads zero");
    @(negedge clk);
    check({64'd0, pad_oe}, 128'h0000_0100_0000_00FB, "R10 oe unchanged");
    check({64'd0, pad_out}, 128'h0000_0001_0000_000C, "R10 out unchanged");
    check(alt_sel, 128'h20, "R10 alt unchanged");

    // R3 back to input
    wr(8'h08, 32'h0);
    check({64'd0, pad_oe}, 128'h0000_0100_0000_0000, "R3 word0 inputs");

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check({64'd0, pad_oe}, 128'd0, "R1 oe cleared by reset");
    check({64'd0, pad_out}, 128'd0, "R1 out cleared by reset");
    check(alt_sel, 128'd0, "R1 alt cleared by reset");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule